// File: doc/BRIEF.md
# Modified Miller Pattern Transmitter

This block is the reader-to-card transmit path of a 106 kbit/s proximity-card front end. Software pre-codes a frame into 2-bit half-period patterns and pushes them into a queue. A start command then replays the queue onto `tx_out` as an on/off carrier envelope, one pattern per bit period. The host does all of the framing: the start symbol, the Miller-coded data bits with parity, and the closing symbols. The block only times and shapes the patterns.

A bit period is `BIT_CLKS` system clocks. The default of 944 matches 128 carrier cycles at a 100 MHz system clock. The high bit of a pattern shapes the first half of the period and the low bit shapes the second half. A 0 in either half means a modulation pause. The three legal patterns are X = 2'b10, Y = 2'b11 and Z = 2'b01.

`busy` stays high while the queue is played out, plus one trailing period of unmodulated carrier. Each accepted start also emits a one-cycle `rx_flush` pulse, which clears the neighbouring receive path.

Top module: `miller_pattern_tx`

## Requirements
- R1: After reset, `busy` and `rx_flush` are 0, the queue is empty, and the carrier is on.
- R2: With `pol_hi`=1, `tx_out` is 1 while the carrier is on and 0 during a pause. With `pol_hi`=0 the output is inverted.
- R3: The start edge that accepts a frame counts as cycle 0. Symbol k occupies cycles k*BIT_CLKS to (k+1)*BIT_CLKS-1. The first BIT_CLKS/2 of those cycles follow pattern bit 1 and the rest follow bit 0, where a bit value of 0 means a pause. X=2'b10, Y=2'b11, Z=2'b01.
- R4: `sym_we` while `busy` is 1 stores nothing.
- R5: `busy` rises one cycle after a start is accepted with N queued symbols. It stays high for (N+1)*BIT_CLKS cycles, and the carrier is on throughout the final period.
- R6: The queue holds DEPTH patterns. A write to a full queue is dropped.
- R7: `rx_flush` pulses for one cycle after every `start` that is sampled while not busy.
- R8: A `start` with an empty queue does not raise `busy` and causes no modulation.
- R9: A `start` while `busy` is 1 is ignored.
- R10: Patterns go out in write order, and the queue is empty when `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_we | input | 1 | Push `sym_pat` into the queue |
| sym_pat | input | 2 | Half-period pattern (bit 1 = first half) |
| start | input | 1 | Launch transmission of the queue |
| pol_hi | input | 1 | 1: carrier-on shown as 1 on `tx_out` |
| tx_out | output | 1 | Modulation envelope |
| busy | output | 1 | Transmission in progress |
| rx_flush | output | 1 | One-cycle pulse to clear the receive path |

## Verification
The bound checker verifies several properties on every cycle:
- the idle output level under either polarity;
- that `busy` only rises after a start;
- the one-cycle timing of `rx_flush` and its suppression while busy;
- that the queue level never exceeds DEPTH and never grows while busy;
- that the queue is empty when `busy` falls;
- that an empty-queue start stays idle.

Other behaviours can only be shown by the bench scenarios, which compare the outputs against a behavioural model on every clock. These include the exact half-period shape of each X, Y and Z pattern, the symbol order, the (N+1)-period busy length, the dropping of writes beyond a full queue, and the inverted-polarity pause pattern.

// File: rtl/mpt_pkg.sv
// Package: shared types and pattern constants for the pattern transmitter.
// Assumes patterns are 2 bits, with bit 1 shaping the first half-period.
package mpt_pkg;
    typedef logic [1:0] pat_t;

    localparam pat_t PAT_X = 2'b10;
    localparam pat_t PAT_Y = 2'b11;
    localparam pat_t PAT_Z = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } tx_state_t;
endpackage

// File: rtl/mpt_sym_queue.sv
// Module: first-in first-out store of 2-bit patterns.
// Assumes push and pop requests are already qualified by the controller.
// A push to a full queue and a pop from an empty queue are ignored.
module mpt_sym_queue
    import mpt_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  pat_t          push_pat,
    input  logic          pop_req,
    output pat_t          head,
    output logic          empty,
    output logic [LW-1:0] level
);
    pat_t          mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    // Qualify the requests against the fill level.
    always_comb begin
        do_push = push_req && (level != LW'(DEPTH));
        do_pop  = pop_req && (level != '0);
    end

    assign empty = (level == '0);
    assign head  = mem[rd_ptr];

    // Storage array write port (no reset is needed on the data).
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_pat;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/mpt_bit_timer.sv
// Module: bit-period timebase producing mid-period and end-of-period ticks.
// Assumes BIT_CLKS >= 4. The count holds at zero while clr is high.
module mpt_bit_timer #(
    parameter int BIT_CLKS = 944,
    localparam int HALF_CLKS = BIT_CLKS / 2,
    localparam int CW = $clog2(BIT_CLKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic half_tick,
    output logic end_tick
);
    logic [CW-1:0] cnt;

    // Decode the last cycle of each half-period.
    always_comb begin
        half_tick = (cnt == CW'(HALF_CLKS - 1));
        end_tick  = (cnt == CW'(BIT_CLKS - 1));
    end

    // Wrapping period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (en)       cnt <= end_tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/mpt_seq_ctrl.sv
// Module: sequencer that accepts start, pops patterns and shapes the envelope.
// Assumes the timer is cleared while idle, so a frame starts at count zero.
// The level output is 1 for carrier-on and 0 for a pause.
module mpt_seq_ctrl
    import mpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic q_empty,
    input  pat_t q_head,
    input  logic half_tick,
    input  logic end_tick,
    output logic pop,
    output logic busy,
    output logic level,
    output logic tmr_clr,
    output logic tmr_en,
    output logic flush
);
    tx_state_t st;
    pat_t      cur;
    logic      launch;
    logic      advance;

    // Decide when to take a pattern from the queue.
    always_comb begin
        launch  = (st == ST_IDLE) && start && !q_empty;
        advance = (st == ST_RUN) && end_tick && !q_empty;
        pop     = launch || advance;
        busy    = (st != ST_IDLE);
        tmr_clr = (st == ST_IDLE);
        tmr_en  = (st != ST_IDLE);
    end

    // Frame state machine and half-period envelope register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cur   <= PAT_Y;
            level <= 1'b1;
            flush <= 1'b0;
        end else begin
            flush <= start && (st == ST_IDLE);
            case (st)
                ST_IDLE: begin
                    if (launch) begin
                        st    <= ST_RUN;
                        cur   <= q_head;
                        level <= q_head[1];
                    end
                end
                ST_RUN: begin
                    if (end_tick) begin
                        if (!q_empty) begin
                            cur   <= q_head;
                            level <= q_head[1];
                        end else begin
                            st    <= ST_TAIL;
                            level <= 1'b1;
                        end
                    end else if (half_tick) begin
                        level <= cur[0];
                    end
                end
                ST_TAIL: begin
                    if (end_tick) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/miller_pattern_tx.sv
// Module: top of the pattern transmitter. It queues host patterns, plays
// them out one per bit period, and applies the output polarity.
// Assumes software supplies a fully framed, Miller-coded pattern list.
module miller_pattern_tx
    import mpt_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int BIT_CLKS = 944,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_we,
    input  logic [1:0] sym_pat,
    input  logic       start,
    input  logic       pol_hi,
    output logic       tx_out,
    output logic       busy,
    output logic       rx_flush
);
    logic          pop;
    logic          q_empty;
    pat_t          q_head;
    logic [LW-1:0] q_level;
    logic          half_tick;
    logic          end_tick;
    logic          tmr_clr;
    logic          tmr_en;
    logic          level;
    logic          push_ok;

    // Writes are only accepted between frames.
    assign push_ok = sym_we && !busy;

    mpt_sym_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_ok),
        .push_pat (sym_pat),
        .pop_req  (pop),
        .head     (q_head),
        .empty    (q_empty),
        .level    (q_level)
    );

    mpt_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tmr_clr),
        .en        (tmr_en),
        .half_tick (half_tick),
        .end_tick  (end_tick)
    );

    mpt_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .half_tick (half_tick),
        .end_tick  (end_tick),
        .pop       (pop),
        .busy      (busy),
        .level     (level),
        .tmr_clr   (tmr_clr),
        .tmr_en    (tmr_en),
        .flush     (rx_flush)
    );

    // Output polarity: carrier-on shows as pol_hi.
    assign tx_out = level ~^ pol_hi;
endmodule

// File: rtl/miller_pattern_tx_chk.sv
// Module: property checker for the pattern transmitter, bound to the top.
// Assumes it sees the top ports plus the queue fill level.
module miller_pattern_tx_chk #(
    parameter int DEPTH = 2048,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          pol_hi,
    input logic          tx_out,
    input logic          busy,
    input logic          rx_flush,
    input logic [LW-1:0] q_level
);
    // R1 / R2: while idle, the carrier is on under the selected polarity.
    assert_idle_carrier_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_out == pol_hi));

    // R5: busy only rises after a start.
    assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7: a flush pulse follows an idle start.
    assert_flush_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> $past(start && !busy));

    // R9: a start while busy gives no flush.
    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !rx_flush);

    // R6: the queue level never exceeds its depth.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= LW'(DEPTH));

    // R4: the queue never grows while busy.
    assert_no_write_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (q_level <= $past(q_level)));

    // R10: the queue is drained when busy falls.
    assert_drained_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (q_level == '0));

    // R8: a start on an empty queue stays idle.
    assert_empty_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && q_level == '0) |=> !busy);
endmodule

bind miller_pattern_tx miller_pattern_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pol_hi   (pol_hi),
    .tx_out   (tx_out),
    .busy     (busy),
    .rx_flush (rx_flush),
    .q_level  (q_level)
);

// File: tb/miller_pattern_tx_tb.sv
module miller_pattern_tx_tb;
    localparam int DEPTH = 8;
    localparam int BITC  = 16;
    localparam int HALFC = BITC / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_we = 1'b0;
    logic [1:0] sym_pat = 2'b00;
    logic       start = 1'b0;
    logic       pol_hi = 1'b1;
    logic       tx_out, busy, rx_flush;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    miller_pattern_tx #(.DEPTH(DEPTH), .BIT_CLKS(BITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .sym_we(sym_we), .sym_pat(sym_pat),
        .start(start), .pol_hi(pol_hi), .tx_out(tx_out), .busy(busy),
        .rx_flush(rx_flush)
    );

    // Behavioural reference model.
    int   mq[$];
    int   sent[$];
    int   mk;
    int   mn;
    logic m_busy = 1'b0;
    logic m_lvl = 1'b1;
    logic m_flush = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); sent.delete();
            m_busy = 1'b0; m_lvl = 1'b1; m_flush = 1'b0; mk = 0; mn = 0;
        end else begin
            m_flush = start && !m_busy;
            if (m_busy) begin
                mk++;
                if (mk == (mn + 1) * BITC) begin
                    m_busy = 1'b0; m_lvl = 1'b1;
                end else if (mk < mn * BITC) begin
                    m_lvl = (mk % BITC < HALFC) ? sent[mk / BITC][1] : sent[mk / BITC][0];
                end else m_lvl = 1'b1;
            end else begin
                if (sym_we && mq.size() < DEPTH) mq.push_back(int'(sym_pat));
                if (start && mq.size() > 0) begin
                    sent = mq; mq.delete();
                    mn = sent.size(); mk = 0; m_busy = 1'b1;
                    m_lvl = sent[0][1];
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(tx_out === (m_lvl ~^ pol_hi), "R3 tx_out shape", int'(tx_out), int'(m_lvl ~^ pol_hi));
            check(busy === m_busy, "R5 busy", int'(busy), int'(m_busy));
            check(rx_flush === m_flush, "R7 rx_flush", int'(rx_flush), int'(m_flush));
        end
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic put(input logic [1:0] p);
        sym_we = 1'b1; sym_pat = p; tick(1); sym_we = 1'b0;
    endtask

    // Miller-code a bit list into patterns (X=10, Y=11, Z=01).
    task automatic put_frame(input int bits[$]);
        int prev = 0;
        put(2'b01);
        foreach (bits[i]) begin
            if (bits[i] == 1) put(2'b10);
            else if (prev == 0) put(2'b01);
            else put(2'b11);
            prev = bits[i];
        end
        put(prev == 0 ? 2'b01 : 2'b11);
        put(2'b11);
    endtask

    // Start, then count busy cycles and pause cycles until busy falls.
    task automatic run(output int nbusy, output int npause, input bit poke);
        nbusy = 0; npause = 0;
        start = 1'b1; tick(1); start = 1'b0;
        for (int i = 0; i < 5000 && busy; i++) begin
            nbusy++;
            if (tx_out != pol_hi) npause++;
            if (poke && i == 20) begin sym_we = 1'b1; sym_pat = 2'b01; start = 1'b1; end
            if (poke && i == 22) begin sym_we = 1'b0; start = 1'b0; end
            tick(1);
        end
    endtask

    initial begin
        int nb, np;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check(busy == 0 && rx_flush == 0 && tx_out == 1, "R1 reset state", int'({busy, rx_flush, tx_out}), 1);

        // Frame 1,0,0,1 -> Z X Y Z X Y Y; writes and start poked mid-frame.
        put_frame('{1, 0, 0, 1});
        run(nb, np, 1'b1);
        check(nb == 8 * BITC, "R5 busy length", nb, 8 * BITC);
        check(np == 4 * HALFC, "R3 pause count", np, 4 * HALFC);
        tick(2);
        // Queue drained and mid-frame writes dropped: a new start stays idle.
        run(nb, np, 1'b0);
        check(nb == 0, "R4 R10 no leftover after busy writes", nb, 0);

        // Overflow: ten writes, only DEPTH kept.
        for (int i = 0; i < 10; i++) put((i % 2) ? 2'b10 : 2'b11);
        run(nb, np, 1'b0);
        check(nb == (DEPTH + 1) * BITC, "R6 full queue drops extra", nb, (DEPTH + 1) * BITC);
        check(np == 4 * HALFC, "R6 R10 order pauses", np, 4 * HALFC);

        // Inverted polarity.
        pol_hi = 1'b0; tick(2);
        check(tx_out == 1'b0, "R2 idle inverted", int'(tx_out), 0);
        put_frame('{0, 1});
        run(nb, np, 1'b0);
        check(np == 3 * HALFC, "R2 inverted pauses", np, 3 * HALFC);
        pol_hi = 1'b1; tick(2);

        // Empty start.
        run(nb, np, 1'b0);
        check(nb == 0 && np == 0, "R8 empty start idle", nb, 0);
        tick(4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule